// File: doc/BRIEF.md
# UART Hardware Handshake Flow Controller

This block connects a UART receive FIFO, a UART transmitter and the modem handshake pins. It watches the receive FIFO fill level and drives an active-low request output with hysteresis. The request is withdrawn when the level reaches a high threshold. It is raised again only when the level drops to a low threshold. It also watches an active-low clear input from the far end and gives the transmitter a start enable. A pause from that input is applied only between characters, never in the middle of one.

A receive interrupt is raised while the FIFO level is at or above a trigger level. The handshake can be placed on either of two pin pairs: the request-to-send/clear-to-send pair, or the data-terminal-ready/data-set-ready pair. The two pairs behave the same. The FIFO storage and the serial shifters sit outside this block.

Top module: `uart_hs_flow`

## Requirements
- R1: After reset, `rts_no` is low (asserted), `dtr_no` is high, `tx_en_o` is high and `rx_irq_o` is low.
- R2: With `flow_mode_i` = 3'b001 and valid thresholds, the selected request pin goes high on the clock edge after `rx_level_i` >= `rts_hi_i`.
- R3: Once high, the selected request pin stays high while the level is between the thresholds. It returns low on the clock edge after `rx_level_i` <= `rts_lo_i`.
- R4: With `flow_mode_i` = 3'b001, the selected clear input is passed through a two-flop synchronizer. When it reads high and the transmitter is idle, `tx_en_o` falls three clock edges after the pin changes. When it reads low again, `tx_en_o` rises three clock edges after the pin changes.
- R5: While `tx_busy_i` is high and `tx_char_done_i` is low, `tx_en_o` does not fall. A pending pause takes effect on the edge after `tx_char_done_i` is sampled high.
- R6: `rx_irq_o` is high on the clock edge after `rx_level_i` >= `rx_trig_i`, and low on the edge after the level drops below it.
- R7: With `pin_mode_i` = 3'b010, the handshake uses `dtr_no` as the request pin and `dsr_ni` as the clear input, and `rts_no` is held high. Otherwise the pair `rts_no`/`cts_ni` is used and `dtr_no` is held high.
- R8: With `flow_mode_i` other than 3'b001, the selected request pin is held low and `tx_en_o` is high whatever the level and clear input.
- R9: If `rts_lo_i` >= `rts_hi_i`, `thr_err_o` is high and the selected request pin is held low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flow_mode_i | input | 3 | Flow mode; 3'b001 enables the hardware handshake |
| pin_mode_i | input | 3 | Pin select; 3'b010 moves the handshake to DTR/DSR |
| rx_level_i | input | LVL_W | Receive FIFO fill level |
| rts_hi_i | input | LVL_W | High threshold; request withdrawn |
| rts_lo_i | input | LVL_W | Low threshold; request restored |
| rx_trig_i | input | LVL_W | Receive interrupt trigger level |
| cts_ni | input | 1 | Clear-to-send pin, active low, asynchronous |
| dsr_ni | input | 1 | Data-set-ready pin, active low, asynchronous |
| tx_busy_i | input | 1 | Transmitter is shifting a character |
| tx_char_done_i | input | 1 | Pulse when the current character completes |
| rts_no | output | 1 | Request-to-send pin, active low |
| dtr_no | output | 1 | Data-terminal-ready pin, active low |
| tx_en_o | output | 1 | Transmitter may start a new character |
| rx_irq_o | output | 1 | Receive FIFO trigger interrupt |
| thr_err_o | output | 1 | Threshold pair is invalid |

## Verification
Some rules are checked by the assertions on every cycle. The request pin follows the thresholds. The request is held low outside handshake mode. The enable never drops in the middle of a character. A clear input that reads active restores the enable. The interrupt tracks the trigger level. The bench scenarios are needed for the rest: the exact latency through the synchronizer, the hysteresis band seen from both sides, the move to the alternate pin pair with the unused request pin parked high, and the fallback when the thresholds are invalid.

// File: rtl/uart_hs_pkg.sv
package uart_hs_pkg;
  localparam logic [2:0] FLOW_HW = 3'b001;
  localparam logic [2:0] PIN_ALT = 3'b010;
endpackage

// File: rtl/uart_hs_sync.sv
module uart_hs_sync #(
  parameter int W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic [1:0] ff_q;
    // reset to 0: peer reads as ready
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ff_q <= '0;
      else         ff_q <= {ff_q[0], d_i[g]};
    end
    assign q_o[g] = ff_q[1];
  end
endmodule

// File: rtl/uart_hs_rts.sv
module uart_hs_rts #(
  parameter int LVL_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [LVL_W-1:0] level_i,
  input  logic [LVL_W-1:0] hi_i,
  input  logic [LVL_W-1:0] lo_i,
  output logic             stop_o,
  output logic             err_o
);
  logic valid;
  assign valid = lo_i < hi_i;
  assign err_o = ~valid;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  stop_o <= 1'b0;
    else if (!en_i || !valid)     stop_o <= 1'b0;
    else if (level_i >= hi_i)     stop_o <= 1'b1;
    else if (level_i <= lo_i)     stop_o <= 1'b0;
  end

  p_stop_at_hi_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && valid && level_i >= hi_i |=> stop_o);
  p_go_at_lo_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_i <= lo_i |=> !stop_o);
  p_off_mode_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !stop_o);
  p_bad_thr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid |=> !stop_o);
endmodule

// File: rtl/uart_hs_txgate.sv
module uart_hs_txgate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic peer_off_i,
  input  logic busy_i,
  input  logic done_i,
  output logic hold_o
);
  logic boundary;
  assign boundary = ~busy_i | done_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     hold_o <= 1'b0;
    else if (!en_i || !peer_off_i)   hold_o <= 1'b0;
    else if (boundary)               hold_o <= 1'b1;
  end

  p_no_mid_char_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && !done_i && !hold_o |=> !hold_o);
  p_resume_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !peer_off_i |=> !hold_o);
  p_free_mode_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !hold_o);
endmodule

// File: rtl/uart_hs_flow.sv
module uart_hs_flow
  import uart_hs_pkg::*;
#(
  parameter int LVL_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       flow_mode_i,
  input  logic [2:0]       pin_mode_i,
  input  logic [LVL_W-1:0] rx_level_i,
  input  logic [LVL_W-1:0] rts_hi_i,
  input  logic [LVL_W-1:0] rts_lo_i,
  input  logic [LVL_W-1:0] rx_trig_i,
  input  logic             cts_ni,
  input  logic             dsr_ni,
  input  logic             tx_busy_i,
  input  logic             tx_char_done_i,
  output logic             rts_no,
  output logic             dtr_no,
  output logic             tx_en_o,
  output logic             rx_irq_o,
  output logic             thr_err_o
);
  logic       hw_en, alt_pins, peer_off, stop, hold;
  logic [1:0] pins_s;

  assign hw_en    = flow_mode_i == FLOW_HW;
  assign alt_pins = pin_mode_i == PIN_ALT;

  uart_hs_sync #(.W(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({dsr_ni, cts_ni}),
    .q_o   (pins_s)
  );

  assign peer_off = alt_pins ? pins_s[1] : pins_s[0];

  uart_hs_rts #(.LVL_W(LVL_W)) u_rts (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (hw_en),
    .level_i(rx_level_i),
    .hi_i   (rts_hi_i),
    .lo_i   (rts_lo_i),
    .stop_o (stop),
    .err_o  (thr_err_o)
  );

  uart_hs_txgate u_gate (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (hw_en),
    .peer_off_i(peer_off),
    .busy_i    (tx_busy_i),
    .done_i    (tx_char_done_i),
    .hold_o    (hold)
  );

  // unused request pin parks inactive (high)
  assign rts_no  = alt_pins ? 1'b1 : stop;
  assign dtr_no  = alt_pins ? stop : 1'b1;
  assign tx_en_o = ~hold;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rx_irq_o <= 1'b0;
    else         rx_irq_o <= rx_level_i >= rx_trig_i;
  end

  p_irq_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_level_i >= rx_trig_i |=> rx_irq_o);
  p_pin_park_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rts_no || dtr_no);
endmodule

// File: tb/uart_hs_flow_tb.sv
module uart_hs_flow_tb;
  localparam int LVL_W = 6;

  typedef struct {
    string tag;
    bit rts, dtr, txen, irq, err;
  } exp_t;

  logic             clk_i = 0, rst_ni = 0;
  logic [2:0]       flow_mode_i = 3'b000, pin_mode_i = 3'b000;
  logic [LVL_W-1:0] rx_level_i = '0, rts_hi_i = 6'd24, rts_lo_i = 6'd8, rx_trig_i = 6'd16;
  logic             cts_ni = 0, dsr_ni = 0, tx_busy_i = 0, tx_char_done_i = 0;
  logic             rts_no, dtr_no, tx_en_o, rx_irq_o, thr_err_o;

  int   checks = 0, errors = 0;
  exp_t q[$];
  bit   done = 0;

  uart_hs_flow #(.LVL_W(LVL_W)) u_dut (.*);

  always #5 clk_i = ~clk_i;

  task automatic expect_after(string tag, int n, bit rts, bit dtr, bit txen, bit irq, bit err);
    exp_t e;
    repeat (n) @(negedge clk_i);
    e.tag = tag; e.rts = rts; e.dtr = dtr; e.txen = txen; e.irq = irq; e.err = err;
    q.push_back(e);
    #1;
  endtask

  // monitor: compares each expected item with the outputs
  initial begin
    forever begin
      exp_t e;
      wait (q.size() != 0);
      e = q.pop_front();
      checks++;
      if ({rts_no, dtr_no, tx_en_o, rx_irq_o, thr_err_o} !== {e.rts, e.dtr, e.txen, e.irq, e.err}) begin
        errors++;
        $display("FAIL %s actual rts/dtr/txen/irq/err=%b%b%b%b%b expected=%b%b%b%b%b", e.tag,
                 rts_no, dtr_no, tx_en_o, rx_irq_o, thr_err_o, e.rts, e.dtr, e.txen, e.irq, e.err);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    expect_after("R1 reset state", 0, 0, 1, 1, 0, 0);
    rst_ni = 1;
    flow_mode_i = 3'b001;
    rx_level_i = 6'd10;
    expect_after("R2 below high", 2, 0, 1, 1, 0, 0);
    rx_level_i = 6'd24;
    expect_after("R2 reach high", 1, 1, 1, 1, 1, 0);
    rx_level_i = 6'd15;
    expect_after("R3 hysteresis hold", 2, 1, 1, 1, 0, 0);
    rx_level_i = 6'd8;
    expect_after("R3 reach low", 1, 0, 1, 1, 0, 0);
    rx_level_i = 6'd20;
    expect_after("R3 rising in band", 2, 0, 1, 1, 1, 0);
    rx_level_i = 6'd15;
    expect_after("R6 irq clears", 1, 0, 1, 1, 0, 0);
    rx_level_i = 6'd0;
    cts_ni = 1;
    expect_after("R4 two edges no pause yet", 2, 0, 1, 1, 0, 0);
    expect_after("R4 pause on third edge", 1, 0, 1, 0, 0, 0);
    cts_ni = 0;
    expect_after("R4 still paused", 2, 0, 1, 0, 0, 0);
    expect_after("R4 resume on third edge", 1, 0, 1, 1, 0, 0);
    tx_busy_i = 1;
    cts_ni = 1;
    expect_after("R5 no pause mid char", 6, 0, 1, 1, 0, 0);
    tx_char_done_i = 1;
    @(negedge clk_i);
    tx_char_done_i = 0;
    tx_busy_i = 0;
    expect_after("R5 pause at char end", 0, 0, 1, 0, 0, 0);
    cts_ni = 0;
    expect_after("R4 resume", 4, 0, 1, 1, 0, 0);
    flow_mode_i = 3'b010;
    rx_level_i = 6'd30;
    cts_ni = 1;
    expect_after("R8 other mode free", 5, 0, 1, 1, 1, 0);
    cts_ni = 0;
    rx_level_i = 6'd0;
    flow_mode_i = 3'b001;
    pin_mode_i = 3'b010;
    expect_after("R7 alt idle", 4, 1, 0, 1, 0, 0);
    rx_level_i = 6'd30;
    expect_after("R7 dtr withdrawn", 1, 1, 1, 1, 1, 0);
    cts_ni = 1;
    expect_after("R7 cts ignored in alt", 4, 1, 1, 1, 1, 0);
    dsr_ni = 1;
    expect_after("R7 dsr pauses", 4, 1, 1, 0, 1, 0);
    dsr_ni = 0;
    cts_ni = 0;
    pin_mode_i = 3'b000;
    rx_level_i = 6'd30;
    expect_after("R7 back to rts", 4, 1, 1, 1, 1, 0);
    rts_lo_i = 6'd24;
    expect_after("R9 invalid thresholds", 1, 0, 1, 1, 1, 1);
    rts_lo_i = 6'd30;
    expect_after("R9 lo above hi", 2, 0, 1, 1, 1, 1);
    #2;
    wait (q.size() == 0);
    #1;
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule